// File: doc/BRIEF.md
# Four-Channel Double-Buffered Analog Output Register Set

This block holds the bus-side registers for four analog output channels. Each channel has a 12-bit output code plus a polarity select and a gain select. A 16-bit bus with a byte address, a write strobe and a read strobe reaches all registers. Every register is write-only. Reads of two particular offsets do not return data; they act as transfer commands.

A mode register sets two things: whether the outputs are enabled, and whether the block works in direct or double-buffered fashion. In direct mode, a write to a data or configuration register takes effect at the outputs on the next clock edge. In double-buffered mode, writes land only in shadow registers. A read of the configuration offset moves the shadow polarity and gain bits into the active outputs. A read of the mode offset moves all four shadow codes into the active codes in the same cycle, so the four channels change together.

While the outputs are disabled, each channel's code is forced to an idle value. That value is mid-scale for a bipolar channel and zero for a unipolar one. The active registers keep their contents and appear again once the outputs are re-enabled.

Top module: `dac4_dbuf_regs`

## Requirements
- R1: A synchronous reset clears the mode bits, the configuration (shadow and active) and the data registers (shadow and active). On the cycle after reset, every code, polarity and gain output reads 0.
- R2: A write to byte offset 0x02 loads the mode. Bit 1 is output enable (1 = enabled) and bit 0 is buffered mode (1 = double-buffered). The other bits are ignored.
- R3: A write to offset 0x12 carries the channel configuration. For channel n (n = 0..3), bit 7-n selects bipolar (1) or unipolar (0), and bit 11-n selects gain 1 (1) or gain 0 (0). Bits 3:0 and 15:12 are ignored.
- R4: In buffered mode, a configuration write does not change the polarity or gain outputs. A bus read of offset 0x12 copies the written configuration to those outputs on the next edge.
- R5: In buffered mode, a write to a data register does not change any active code. A bus read of offset 0x02 copies all four shadow codes into the active codes on the same edge.
- R6: In direct mode (bit 0 = 0), a write to the data register of channel n at offset 0x14 + 2n updates that channel's active code on the next edge. A configuration write updates the polarity and gain outputs on the next edge.
- R7: A data register keeps only bits 11:0 of a write. Bits 15:12 have no effect on the code.
- R8: While output enable is 0, each channel's code output is 0x800 if its active polarity is bipolar and 0x000 if unipolar. The active code is preserved and reappears when enable returns to 1.
- R9: Writes to unmapped offsets (for example 0x00, 0x04, 0x1C) change no output. Reads of any offset other than 0x02 and 0x12 change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; offsets 0x02 and 0x12 act as transfer commands |
| dac_code | output | 48 | Four 12-bit output codes; channel n occupies bits 12n+11:12n |
| dac_bipolar | output | 4 | Active polarity per channel, 1 = bipolar |
| dac_gain | output | 4 | Active gain select per channel, 1 = gain 1 |

## Verification
Assertions check the following on every cycle:
- Each active code and the active configuration hold still in buffered mode unless a transfer read occurs.
- A transfer moves exactly the shadow contents into the active registers.
- A direct-mode write appears on the following edge.
- A mode write loads both bits.
- Reset leaves all outputs at zero.

Some behaviour only the bench's scenarios can show:
- The reversed bit layout of the configuration word, swept over all 256 polarity and gain combinations.
- Masking of the top four data bits over a sweep of codes on each channel.
- The idle codes while disabled, and the return of preserved codes after re-enable.
- That stray reads and writes to unmapped offsets leave the outputs untouched.

// File: rtl/dac4_pkg.sv
package dac4_pkg;

    // Channel count and widths
    localparam int unsigned CH_N   = 4;
    localparam int unsigned CODE_W = 12;
    localparam int unsigned BUS_W  = 16;
    localparam int unsigned ADDR_W = 5;

    // Byte offsets the block answers
    localparam logic [ADDR_W-1:0] OFS_MODE  = 5'h02;
    localparam logic [ADDR_W-1:0] OFS_CFG   = 5'h12;
    localparam logic [ADDR_W-1:0] OFS_DATA0 = 5'h14;

    // Bit positions inside the configuration word (channel n uses TOP-n)
    localparam int unsigned POL_TOP  = 7;
    localparam int unsigned GAIN_TOP = 11;

    // Bit positions inside the mode word
    localparam int unsigned MODE_EN_BIT  = 1;
    localparam int unsigned MODE_BUF_BIT = 0;

    typedef struct packed {
        logic enable;
        logic buffered;
    } mode_t;

    typedef struct packed {
        logic [CH_N-1:0] bipolar;
        logic [CH_N-1:0] gain;
    } cfg_t;

    typedef struct packed {
        logic            mode_wr;
        logic            cfg_wr;
        logic            cfg_xfer;
        logic            data_xfer;
        logic [CH_N-1:0] data_wr;
    } strobe_t;

    // R3: channel n reads polarity from bit POL_TOP-n and gain from GAIN_TOP-n
    function automatic cfg_t unpack_cfg(input logic [BUS_W-1:0] word);
        cfg_t c;
        for (int n = 0; n < CH_N; n++) begin
            c.bipolar[n] = word[POL_TOP-n];
            c.gain[n]    = word[GAIN_TOP-n];
        end
        return c;
    endfunction

    // R8: idle code while outputs are disabled
    function automatic logic [CODE_W-1:0] idle_code(input logic bipolar);
        return bipolar ? (CODE_W'(1) << (CODE_W-1)) : '0;
    endfunction

    // Data register of channel n sits at OFS_DATA0 + 2n
    function automatic logic [ADDR_W-1:0] data_offset(input int unsigned n);
        return OFS_DATA0 + ADDR_W'(2*n);
    endfunction

endpackage

// File: rtl/dac4_decode.sv
module dac4_decode
    import dac4_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output strobe_t           strb
);

    logic [CH_N-1:0] data_hit;

    // One comparator per channel data register
    for (genvar g = 0; g < CH_N; g++) begin : g_data_hit
        assign data_hit[g] = bus_wr && (bus_addr == data_offset(g));
    end

    // R9: any other offset produces no strobe at all
    always_comb begin
        strb           = '0;
        strb.mode_wr   = bus_wr && (bus_addr == OFS_MODE);
        strb.cfg_wr    = bus_wr && (bus_addr == OFS_CFG);
        strb.cfg_xfer  = bus_rd && (bus_addr == OFS_CFG);
        strb.data_xfer = bus_rd && (bus_addr == OFS_MODE);
        strb.data_wr   = data_hit;
    end

endmodule

// File: rtl/dac4_mode_reg.sv
module dac4_mode_reg
    import dac4_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] wbits,
    output mode_t      mode
);

    mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr) begin
            mode_q.enable   <= wbits[MODE_EN_BIT];
            mode_q.buffered <= wbits[MODE_BUF_BIT];
        end
    end

    assign mode = mode_q;

    // R2: a mode write loads both bits on the next edge
    a_r2_mode_load: assert property (@(posedge clk) disable iff (rst)
        wr |=> (mode_q.enable == $past(wbits[MODE_EN_BIT])) &&
               (mode_q.buffered == $past(wbits[MODE_BUF_BIT])));

endmodule

// File: rtl/dac4_cfg_bank.sv
module dac4_cfg_bank
    import dac4_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             buffered,
    input  logic             wr,
    input  logic             xfer,
    input  logic [BUS_W-1:0] wdata,
    output cfg_t             active
);

    cfg_t shadow_q;
    cfg_t active_q;
    cfg_t incoming;

    assign incoming = unpack_cfg(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr) begin
                shadow_q <= incoming;
            end
            // R6: direct mode bypasses the shadow; R4: otherwise wait for xfer
            if (wr && !buffered) begin
                active_q <= incoming;
            end else if (xfer) begin
                active_q <= shadow_q;
            end
        end
    end

    assign active = active_q;

    // R4: buffered configuration holds until a transfer read
    a_r4_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (buffered && !xfer) |=> $stable(active_q));

    // R4: a transfer read moves the shadow into the active bits
    a_r4_cfg_xfer: assert property (@(posedge clk) disable iff (rst)
        (xfer && !(wr && !buffered)) |=> (active_q == $past(shadow_q)));

endmodule

// File: rtl/dac4_data_chan.sv
module dac4_data_chan
    import dac4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              buffered,
    input  logic              enable,
    input  logic              bipolar,
    input  logic              wr,
    input  logic              xfer,
    input  logic [CODE_W-1:0] wdata,   // R7: only the low code bits arrive
    output logic [CODE_W-1:0] code_out
);

    logic [CODE_W-1:0] shadow_q;
    logic [CODE_W-1:0] active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr) begin
                shadow_q <= wdata;
            end
            if (wr && !buffered) begin
                active_q <= wdata;
            end else if (xfer) begin
                active_q <= shadow_q;
            end
        end
    end

    // R8: disabled outputs show the idle code, the active code is kept
    assign code_out = enable ? active_q : idle_code(bipolar);

    // R5: buffered code holds until a transfer read
    a_r5_code_hold: assert property (@(posedge clk) disable iff (rst)
        (buffered && !xfer) |=> $stable(active_q));

    // R5: a transfer read moves the shadow into the active code
    a_r5_code_xfer: assert property (@(posedge clk) disable iff (rst)
        (xfer && !(wr && !buffered)) |=> (active_q == $past(shadow_q)));

    // R6: direct-mode writes reach the active code on the next edge
    a_r6_direct_write: assert property (@(posedge clk) disable iff (rst)
        (wr && !buffered) |=> (active_q == $past(wdata)));

endmodule

// File: rtl/dac4_dbuf_regs.sv
module dac4_dbuf_regs
    import dac4_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [BUS_W-1:0]       bus_wdata,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    output logic [CH_N*CODE_W-1:0] dac_code,
    output logic [CH_N-1:0]        dac_bipolar,
    output logic [CH_N-1:0]        dac_gain
);

    strobe_t strb;
    mode_t   mode;
    cfg_t    cfg_act;

    dac4_decode i_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .strb     (strb)
    );

    dac4_mode_reg i_mode (
        .clk   (clk),
        .rst   (rst),
        .wr    (strb.mode_wr),
        .wbits (bus_wdata[1:0]),
        .mode  (mode)
    );

    dac4_cfg_bank i_cfg (
        .clk      (clk),
        .rst      (rst),
        .buffered (mode.buffered),
        .wr       (strb.cfg_wr),
        .xfer     (strb.cfg_xfer),
        .wdata    (bus_wdata),
        .active   (cfg_act)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_chan
        dac4_data_chan i_chan (
            .clk      (clk),
            .rst      (rst),
            .buffered (mode.buffered),
            .enable   (mode.enable),
            .bipolar  (cfg_act.bipolar[g]),
            .wr       (strb.data_wr[g]),
            .xfer     (strb.data_xfer),
            .wdata    (bus_wdata[CODE_W-1:0]),
            .code_out (dac_code[g*CODE_W +: CODE_W])
        );
    end

    assign dac_bipolar = cfg_act.bipolar;
    assign dac_gain    = cfg_act.gain;

    // R1: the cycle after a reset edge shows all outputs cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (dac_code == '0) && (dac_bipolar == '0) && (dac_gain == '0));

endmodule

// File: tb/test_dac4_dbuf_regs.sv
module test_dac4_dbuf_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [47:0] dac_code;
    logic [3:0]  dac_bipolar;
    logic [3:0]  dac_gain;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model state, built from the requirements
    logic [11:0] m_sh [4];
    logic [11:0] m_act[4];
    logic [3:0]  m_pol_sh, m_pol, m_g_sh, m_g;
    logic        m_en, m_buf;

    always #5 clk = ~clk;

    dac4_dbuf_regs i_dac4_dbuf_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .dac_code    (dac_code),
        .dac_bipolar (dac_bipolar),
        .dac_gain    (dac_gain)
    );

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int n = 0; n < 4; n++) begin
            m_sh[n]  = '0;
            m_act[n] = '0;
        end
        m_pol_sh = '0; m_pol = '0; m_g_sh = '0; m_g = '0;
        m_en = 1'b0; m_buf = 1'b0;
    endtask

    task automatic check_all(input string tag);
        logic [47:0] exp_code;
        for (int n = 0; n < 4; n++)
            exp_code[n*12 +: 12] = m_en ? m_act[n] : (m_pol[n] ? 12'h800 : 12'h000);
        check({tag, " code"},    dac_code, exp_code);
        check({tag, " bipolar"}, {44'd0, dac_bipolar}, {44'd0, m_pol});
        check({tag, " gain"},    {44'd0, dac_gain},    {44'd0, m_g});
    endtask

    task automatic do_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 5'h02) begin
            m_en  = d[1];
            m_buf = d[0];
        end else if (a == 5'h12) begin
            for (int n = 0; n < 4; n++) begin
                m_pol_sh[n] = d[7-n];
                m_g_sh[n]   = d[11-n];
            end
            if (!m_buf) begin
                m_pol = m_pol_sh;
                m_g   = m_g_sh;
            end
        end else begin
            for (int n = 0; n < 4; n++) begin
                if (a == 5'(8'h14 + 2*n)) begin
                    m_sh[n] = d[11:0];
                    if (!m_buf) m_act[n] = d[11:0];
                end
            end
        end
    endtask

    task automatic do_read(input logic [4:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        if (a == 5'h02) begin
            for (int n = 0; n < 4; n++) m_act[n] = m_sh[n];
        end else if (a == 5'h12) begin
            m_pol = m_pol_sh;
            m_g   = m_g_sh;
        end
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset");

        // R2: enabled, direct mode
        do_write(5'h02, 16'h0002);
        check_all("R2 mode enable");

        // R6 / R7: direct-mode data sweep with noise in the top bits
        for (int n = 0; n < 4; n++) begin
            for (int k = 0; k < 32; k++) begin
                do_write(5'(8'h14 + 2*n), 16'(k*16'h2F1B + n*16'h1357));
                check_all("R6 direct data");
            end
        end
        do_write(5'h14, 16'hF800);
        check("R7 upper bits dropped", {36'd0, dac_code[11:0]}, {36'd0, 12'h800});
        do_write(5'h1A, 16'h7ABC);
        check("R7 upper bits dropped", {36'd0, dac_code[47:36]}, {36'd0, 12'hABC});

        // R3: every polarity/gain combination, noise in ignored bits
        for (int c = 0; c < 256; c++) begin
            do_write(5'h12, {4'hA, 8'(c), 4'h5});
            check_all("R3 cfg layout");
        end

        // R2: switch to buffered, enabled
        do_write(5'h02, 16'hFFF3);
        check_all("R2 mode buffered");

        // R4: buffered configuration
        do_write(5'h12, 16'h0A50);
        check_all("R4 cfg held");
        do_read(5'h02);
        check_all("R4 cfg held on data xfer");
        do_read(5'h12);
        check_all("R4 cfg transfer");
        check("R4 cfg transfer bipolar", {44'd0, dac_bipolar}, {44'd0, 4'b1010});

        // R5 / R9: buffered data writes, stray read, then transfer
        for (int n = 0; n < 4; n++) begin
            do_write(5'(8'h14 + 2*n), 16'(16'h0321 + n*16'h0404));
            check_all("R5 data held");
        end
        do_read(5'h04);
        check_all("R9 stray read");
        do_read(5'h14);
        check_all("R9 stray read");
        do_read(5'h02);
        check_all("R5 data transfer");

        // R9: unmapped writes
        do_write(5'h1C, 16'hFFFF);
        check_all("R9 unmapped write");
        do_write(5'h04, 16'hFFFF);
        check_all("R9 unmapped write");
        do_write(5'h00, 16'hFFFF);
        check_all("R9 unmapped write");
        do_write(5'h15, 16'hFFFF);
        check_all("R9 unmapped write");

        // R8: disabled, buffered; sweep polarity patterns
        do_write(5'h02, 16'h0001);
        check_all("R8 disabled");
        for (int p = 0; p < 16; p++) begin
            do_write(5'h12, 16'({4'(p), 4'(p)}) << 4);
            do_read(5'h12);
            check_all("R8 idle codes");
        end

        // R8: direct-mode writes while disabled stay hidden, then reappear
        do_write(5'h02, 16'h0000);
        for (int n = 0; n < 4; n++) begin
            do_write(5'(8'h14 + 2*n), 16'(16'h0F0F - n*16'h0111));
            check_all("R8 hidden write");
        end
        do_write(5'h02, 16'h0002);
        check_all("R8 re-enable");

        // R1: reset in the middle of operation
        pulse_reset();
        check_all("R1 mid reset");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule